// File: doc/BRIEF.md
# Configurable Logic-Cell Register Stage

This block is the storage and output-control part of one programmable logic cell. A combinational sum-of-products value comes in. A single flip-flop can hold it as a plain data register or use it as a toggle command. Configuration inputs choose which clock drives the flop and on which edge it captures. They also choose where the capture-enable comes from and whether the cell presents the stored value or the raw combinational value. A last field sets how the pin driver is enabled.

The flop is clocked from one of three global clocks or from a product-term clock, and each cell can invert its chosen clock. The capture-enable is not a gated clock. It is a hold multiplexer that feeds the flop's own output back to its input. The enable may come from its own product term, and the set or reset product term may be borrowed to serve as the enable instead. Product-term set and reset act asynchronously. So does a global set/reset, and a per-cell bit decides whether that global line sets or clears the cell.

The cell has two outputs. A feedback value returns to the interconnect. A pin path carries the same value plus a separate drive-enable. Pad electrical behaviour and path delays are not modelled.

Top module: `mcell_reg_stage`

## Requirements
- R1: With `cfg_t_mode`=0 and capture enabled, the active clock edge loads `sop_in` into the register.
- R2: With `cfg_t_mode`=1 and capture enabled, the active clock edge inverts the register when `sop_in`=1 and leaves it unchanged when `sop_in`=0.
- R3: `cfg_ce_src` selects the capture-enable: 0 = always enabled, 1 = `pt_ce`, 2 = `pt_set`, 3 = `pt_rst`. While the enable is 0, clock edges leave the register unchanged. A term borrowed as the enable (2 or 3) has no asynchronous set or reset effect.
- R4: `cfg_clk_src` value k in 0..2 clocks the register from `gclk[k]`, and value 3 clocks it from `pt_clk`. Edges on unselected clocks have no effect.
- R5: With `cfg_clk_inv`=1 the register captures on the falling edge of the selected clock instead of the rising edge.
- R6: `pt_set`=1 forces the register to 1 and `pt_rst`=1 forces it to 0 at once, without a clock edge. When both are 1 the register is 0.
- R7: While `gsr_n`=0 the register is forced at once to 1 if `cfg_gsr_set`=1, or to 0 if `cfg_gsr_set`=0.
- R8: Asynchronous set and reset take effect while the capture-enable is 0.
- R9: With `cfg_comb_out`=1, `fb_out` and `pin_out` both follow `sop_in` combinationally. With 0, both carry the register value.
- R10: `cfg_oe_src` sets `pin_oe`: 0 = always 0, 1 = always 1, 2 = `pt_oe`, 3 = inverted `pt_oe`.
- R11: `fb_out` and `pin_out` carry the selected cell value whatever the state of `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | NGCK (3) | Global clock sources |
| pt_clk | input | 1 | Product-term clock source |
| gsr_n | input | 1 | Global asynchronous set/reset, active low |
| sop_in | input | 1 | Combinational sum-of-products data |
| pt_set | input | 1 | Product-term asynchronous set, or enable when borrowed |
| pt_rst | input | 1 | Product-term asynchronous reset, or enable when borrowed |
| pt_ce | input | 1 | Product-term capture-enable |
| pt_oe | input | 1 | Product-term pin drive-enable |
| cfg_clk_src | input | SRCW (2) | Clock source index |
| cfg_clk_inv | input | 1 | Invert the selected clock |
| cfg_t_mode | input | 1 | 1 = toggle register, 0 = data register |
| cfg_ce_src | input | 2 | Capture-enable source |
| cfg_comb_out | input | 1 | 1 = bypass the register |
| cfg_oe_src | input | 2 | Pin drive-enable source |
| cfg_gsr_set | input | 1 | Global line sets (1) or clears (0) the cell |
| fb_out | output | 1 | Cell value returned to the interconnect |
| pin_out | output | 1 | Cell value toward the pin |
| pin_oe | output | 1 | Pin drive-enable |

## Verification
The bench drives a borrowed set or reset term to 1 while it serves as the enable. A design that still wired it to the asynchronous input would change the register with no clock edge. It pulses the unselected global clocks and the product-term clock, so a wrong source index shows up as a capture from the wrong clock. It captures on a falling edge with inversion on, which catches an inversion placed after the edge detection or one that is ignored. It also asserts set and reset together, and it fires reset while the enable is low; a design with the wrong priority or with reset gated by the enable leaves a 1 in the register.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  // capture-enable source field
  typedef enum logic [1:0] {
    CE_ALWAYS   = 2'd0,
    CE_PTERM    = 2'd1,
    CE_FROM_SET = 2'd2,
    CE_FROM_RST = 2'd3
  } ce_src_e;

  // pin drive-enable source field
  typedef enum logic [1:0] {
    OE_OFF    = 2'd0,
    OE_ON     = 2'd1,
    OE_PTERM  = 2'd2,
    OE_PTERMN = 2'd3
  } oe_src_e;

endpackage

// File: rtl/mcell_clk_sel.sv
module mcell_clk_sel #(
  parameter int NGCK = 3,
  localparam int NSRC = NGCK + 1,
  localparam int SRCW = $clog2(NSRC)
) (
  input  logic [NGCK-1:0] gclk_i,
  input  logic            pt_clk_i,
  input  logic [SRCW-1:0] src_i,
  input  logic            inv_i,
  output logic            clk_o
);

  logic [NSRC-1:0] src_bus;
  logic [NSRC-1:0] hit;

  // product-term clock sits just above the global clocks
  assign src_bus = {pt_clk_i, gclk_i};

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      assign hit[g] = (src_i == SRCW'(g)) & src_bus[g];
    end
  endgenerate

  assign clk_o = (|hit) ^ inv_i;

endmodule

// File: rtl/mcell_ctl.sv
module mcell_ctl
  import mcell_pkg::*;
(
  input  logic       gsr_n_i,
  input  logic       gsr_set_i,
  input  logic [1:0] ce_src_i,
  input  logic       pt_ce_i,
  input  logic       pt_set_i,
  input  logic       pt_rst_i,
  output logic       ce_o,
  output logic       aset_o,
  output logic       arst_o
);

  ce_src_e sel;
  logic    set_borrowed;
  logic    rst_borrowed;

  assign sel = ce_src_e'(ce_src_i);

  always_comb begin
    ce_o         = 1'b1;
    set_borrowed = 1'b0;
    rst_borrowed = 1'b0;
    case (sel)
      CE_ALWAYS:   ce_o = 1'b1;
      CE_PTERM:    ce_o = pt_ce_i;
      CE_FROM_SET: begin
        ce_o         = pt_set_i;
        set_borrowed = 1'b1;
      end
      CE_FROM_RST: begin
        ce_o         = pt_rst_i;
        rst_borrowed = 1'b1;
      end
      default:     ce_o = 1'b1;
    endcase
  end

  // a term used as the enable loses its asynchronous role
  assign aset_o = (pt_set_i & ~set_borrowed) | (~gsr_n_i & gsr_set_i);
  assign arst_o = (pt_rst_i & ~rst_borrowed) | (~gsr_n_i & ~gsr_set_i);

endmodule

// File: rtl/mcell_ff.sv
module mcell_ff (
  input  logic clk_i,
  input  logic aset_i,
  input  logic arst_i,
  input  logic ce_i,
  input  logic t_mode_i,
  input  logic d_i,
  output logic q_o
);

  logic q_r;
  logic d_eff;
  logic q_nxt;

  // toggle mode turns the data input into an invert command
  always_comb begin
    d_eff = t_mode_i ? (q_r ^ d_i) : d_i;
    q_nxt = ce_i ? d_eff : q_r;
  end

  // reset has priority over set; both bypass the enable
  always_ff @(posedge clk_i or posedge arst_i or posedge aset_i) begin
    if (arst_i)      q_r <= 1'b0;
    else if (aset_i) q_r <= 1'b1;
    else             q_r <= q_nxt;
  end

  assign q_o = q_r;

  // checker helper: cleared by any asynchronous event, set by a clean edge
  logic chk_clean;
  always_ff @(posedge clk_i or posedge arst_i or posedge aset_i) begin
    if (arst_i || aset_i) chk_clean <= 1'b0;
    else                  chk_clean <= 1'b1;
  end

  AST_DATA_LOAD: assert property (@(posedge clk_i) disable iff (arst_i || aset_i)
    (ce_i && !t_mode_i) |=> (!chk_clean || q_r == $past(d_i)));                // R1
  AST_TOGGLE: assert property (@(posedge clk_i) disable iff (arst_i || aset_i)
    (ce_i && t_mode_i && d_i) |=> (!chk_clean || q_r != $past(q_r)));          // R2
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (arst_i || aset_i)
    (!ce_i || (t_mode_i && !d_i)) |=> (!chk_clean || $stable(q_r)));           // R3

endmodule

// File: rtl/mcell_out.sv
module mcell_out
  import mcell_pkg::*;
(
  input  logic       comb_sel_i,
  input  logic       sop_i,
  input  logic       q_i,
  input  logic [1:0] oe_src_i,
  input  logic       pt_oe_i,
  output logic       fb_o,
  output logic       pin_o,
  output logic       pin_oe_o
);

  oe_src_e oe_sel;
  logic    cell_val;

  assign oe_sel   = oe_src_e'(oe_src_i);
  assign cell_val = comb_sel_i ? sop_i : q_i;

  // both paths share one value; only the enable differs
  assign fb_o  = cell_val;
  assign pin_o = cell_val;

  always_comb begin
    case (oe_sel)
      OE_OFF:    pin_oe_o = 1'b0;
      OE_ON:     pin_oe_o = 1'b1;
      OE_PTERM:  pin_oe_o = pt_oe_i;
      OE_PTERMN: pin_oe_o = ~pt_oe_i;
      default:   pin_oe_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/mcell_reg_stage.sv
module mcell_reg_stage #(
  parameter int NGCK = 3,
  localparam int SRCW = $clog2(NGCK + 1)
) (
  input  logic [NGCK-1:0] gclk,
  input  logic            pt_clk,
  input  logic            gsr_n,
  input  logic            sop_in,
  input  logic            pt_set,
  input  logic            pt_rst,
  input  logic            pt_ce,
  input  logic            pt_oe,
  input  logic [SRCW-1:0] cfg_clk_src,
  input  logic            cfg_clk_inv,
  input  logic            cfg_t_mode,
  input  logic [1:0]      cfg_ce_src,
  input  logic            cfg_comb_out,
  input  logic [1:0]      cfg_oe_src,
  input  logic            cfg_gsr_set,
  output logic            fb_out,
  output logic            pin_out,
  output logic            pin_oe
);

  logic ff_clk;
  logic ce;
  logic aset;
  logic arst;
  logic q;

  mcell_clk_sel #(.NGCK(NGCK)) u_clk_sel (
    .gclk_i   (gclk),
    .pt_clk_i (pt_clk),
    .src_i    (cfg_clk_src),
    .inv_i    (cfg_clk_inv),
    .clk_o    (ff_clk)
  );

  mcell_ctl u_ctl (
    .gsr_n_i   (gsr_n),
    .gsr_set_i (cfg_gsr_set),
    .ce_src_i  (cfg_ce_src),
    .pt_ce_i   (pt_ce),
    .pt_set_i  (pt_set),
    .pt_rst_i  (pt_rst),
    .ce_o      (ce),
    .aset_o    (aset),
    .arst_o    (arst)
  );

  mcell_ff u_ff (
    .clk_i    (ff_clk),
    .aset_i   (aset),
    .arst_i   (arst),
    .ce_i     (ce),
    .t_mode_i (cfg_t_mode),
    .d_i      (sop_in),
    .q_o      (q)
  );

  mcell_out u_out (
    .comb_sel_i (cfg_comb_out),
    .sop_i      (sop_in),
    .q_i        (q),
    .oe_src_i   (cfg_oe_src),
    .pt_oe_i    (pt_oe),
    .fb_o       (fb_out),
    .pin_o      (pin_out),
    .pin_oe_o   (pin_oe)
  );

  AST_RESET_WINS: assert property (@(posedge gclk[0]) disable iff (!gsr_n)
    arst |-> !q);                                                              // R6
  AST_SET_APPLIES: assert property (@(posedge gclk[0]) disable iff (!gsr_n)
    (aset && !arst && !pt_rst) |-> q);                                         // R8
  AST_PIN_MATCHES_FB: assert property (@(posedge gclk[0]) disable iff (!gsr_n)
    pin_out == fb_out);                                                        // R11

endmodule

// File: tb/mcell_reg_stage_bench.sv
module mcell_reg_stage_bench;

  logic g0, g1, g2, ptc;
  logic [2:0] gclk;
  logic gsr_n, sop_in, pt_set, pt_rst, pt_ce, pt_oe;
  logic [1:0] cfg_clk_src;
  logic cfg_clk_inv, cfg_t_mode;
  logic [1:0] cfg_ce_src;
  logic cfg_comb_out;
  logic [1:0] cfg_oe_src;
  logic cfg_gsr_set;
  logic fb_out, pin_out, pin_oe;

  int checks = 0;
  int errors = 0;

  assign gclk = {g2, g1, g0};

  mcell_reg_stage u_mcell_reg_stage (
    .gclk(gclk), .pt_clk(ptc), .gsr_n(gsr_n), .sop_in(sop_in),
    .pt_set(pt_set), .pt_rst(pt_rst), .pt_ce(pt_ce), .pt_oe(pt_oe),
    .cfg_clk_src(cfg_clk_src), .cfg_clk_inv(cfg_clk_inv),
    .cfg_t_mode(cfg_t_mode), .cfg_ce_src(cfg_ce_src),
    .cfg_comb_out(cfg_comb_out), .cfg_oe_src(cfg_oe_src),
    .cfg_gsr_set(cfg_gsr_set),
    .fb_out(fb_out), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // 50 MHz global clock 0
  initial g0 = 1'b0;
  always #10 g0 = ~g0;

  // vectors {t_mode, enable, data, expected}, applied on gclk[0] from a cleared register
  localparam logic [3:0] VEC [10] = '{
    4'b0111, 4'b0001, 4'b0100, 4'b1111, 4'b1110,
    4'b1100, 4'b1111, 4'b1011, 4'b1101, 4'b0100
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle();
    @(posedge g0);
    @(negedge g0);
  endtask

  // reconfigure the clock path while the global line holds the cell cleared
  task automatic select_src(input logic [1:0] k, input logic inv);
    @(negedge g0);
    gsr_n = 1'b0;
    cfg_gsr_set = 1'b0;
    cfg_clk_src = k;
    cfg_clk_inv = inv;
    cfg_ce_src = 2'd0;
    cfg_t_mode = 1'b0;
    #2 gsr_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    g1 = 0; g2 = 0; ptc = 0;
    gsr_n = 0; sop_in = 0; pt_set = 0; pt_rst = 0; pt_ce = 0; pt_oe = 0;
    cfg_clk_src = 0; cfg_clk_inv = 0; cfg_t_mode = 0; cfg_ce_src = 0;
    cfg_comb_out = 0; cfg_oe_src = 2'd1; cfg_gsr_set = 0;

    // reset state
    #5;
    chk("R7 reset clears cell", fb_out, 1'b0);
    chk("R11 reset pin value", pin_out, 1'b0);
    chk("R10 oe always on", pin_oe, 1'b1);

    @(negedge g0);
    gsr_n = 1'b1;
    cfg_ce_src = 2'd1;

    // R1 R2 R3 vector walk
    for (int i = 0; i < 10; i++) begin
      cfg_t_mode = VEC[i][3];
      pt_ce      = VEC[i][2];
      sop_in     = VEC[i][1];
      cycle();
      chk(VEC[i][3] ? "R2 toggle vector" : "R1 data vector", fb_out, VEC[i][0]);
    end
    pt_ce = 1'b0;

    // R4 each non-default source
    for (int k = 1; k < 4; k++) begin
      select_src(2'(k), 1'b0);
      sop_in = 1'b1;
      cycle();
      cycle();
      chk("R4 unselected clock ignored", fb_out, 1'b0);
      #2;
      if (k == 1) g1 = 1'b1; else if (k == 2) g2 = 1'b1; else ptc = 1'b1;
      #2 chk("R4 selected source captures", fb_out, 1'b1);
      g1 = 1'b0; g2 = 1'b0; ptc = 1'b0;
    end

    // R5 inverted product-term clock
    select_src(2'd3, 1'b1);
    sop_in = 1'b1;
    #2 ptc = 1'b1;
    #2 chk("R5 rising edge ignored when inverted", fb_out, 1'b0);
    ptc = 1'b0;
    #2 chk("R5 falling edge captures", fb_out, 1'b1);

    // R6 asynchronous set, then set+reset together
    select_src(2'd0, 1'b0);
    sop_in = 1'b0;
    @(negedge g0);
    pt_set = 1'b1;
    #2 chk("R6 async set", fb_out, 1'b1);
    cycle();
    pt_rst = 1'b1;
    #2 chk("R6 reset wins over set", fb_out, 1'b0);
    cycle();
    pt_set = 1'b0; pt_rst = 1'b0;
    #2 chk("R6 released both", fb_out, 1'b0);

    // R8 reset while enable low
    @(negedge g0);
    sop_in = 1'b1;
    cycle();
    chk("R1 load before override", fb_out, 1'b1);
    cfg_ce_src = 2'd1; pt_ce = 1'b0;
    pt_rst = 1'b1;
    #2 chk("R8 reset overrides disabled enable", fb_out, 1'b0);
    cycle();
    pt_rst = 1'b0;
    cycle();
    chk("R3 enable low holds", fb_out, 1'b0);

    // R3 set term borrowed as enable
    cfg_ce_src = 2'd2; pt_set = 1'b0; sop_in = 1'b1;
    cycle();
    chk("R3 borrowed set low holds", fb_out, 1'b0);
    pt_set = 1'b1;
    #2 chk("R3 borrowed set has no async effect", fb_out, 1'b0);
    cycle();
    chk("R3 borrowed set enables capture", fb_out, 1'b1);

    // R3 reset term borrowed as enable
    pt_set = 1'b0; cfg_ce_src = 2'd3; pt_rst = 1'b1; sop_in = 1'b0;
    #2 chk("R3 borrowed reset has no async effect", fb_out, 1'b1);
    cycle();
    chk("R3 borrowed reset enables capture", fb_out, 1'b0);
    pt_rst = 1'b0; cfg_ce_src = 2'd0;

    // R7 global line polarity
    @(negedge g0);
    cfg_gsr_set = 1'b1; gsr_n = 1'b0;
    #2 chk("R7 global line sets", fb_out, 1'b1);
    cfg_gsr_set = 1'b0;
    #2 chk("R7 global line clears", fb_out, 1'b0);
    gsr_n = 1'b1;

    // R9 combinational bypass
    @(negedge g0);
    cfg_comb_out = 1'b1; sop_in = 1'b1;
    #2 chk("R9 bypass feedback", fb_out, 1'b1);
    chk("R9 bypass pin", pin_out, 1'b1);
    sop_in = 1'b0;
    #2 chk("R9 bypass follows low", fb_out, 1'b0);

    // R10 R11 drive-enable sources
    cfg_oe_src = 2'd0; sop_in = 1'b1;
    #2 chk("R10 oe off", pin_oe, 1'b0);
    chk("R11 feedback while oe off", fb_out, 1'b1);
    chk("R11 pin value while oe off", pin_out, 1'b1);
    cfg_oe_src = 2'd2; pt_oe = 1'b1;
    #2 chk("R10 oe from term high", pin_oe, 1'b1);
    pt_oe = 1'b0;
    #2 chk("R10 oe from term low", pin_oe, 1'b0);
    cfg_oe_src = 2'd3;
    #2 chk("R10 inverted term low", pin_oe, 1'b1);
    pt_oe = 1'b1;
    #2 chk("R10 inverted term high", pin_oe, 1'b0);

    #20;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule